// File: doc/BRIEF.md
# Multi-Way Stream Buffer Prefetcher

A small prefetch engine that sits next to a cache and follows sequential or nearly sequential miss streams. It keeps several stream buffers side by side. Each buffer holds a window of consecutive line addresses just ahead of the point its stream has reached. Each slot of that window is in one of four states: unused, waiting to be requested, requested with data still in flight, or data present. Every cache miss is compared against all slots of all buffers in the same cycle. A match reports either "hit" (data present) or "pending" (line requested but not yet returned). The matching buffer then moves forward past the matched slot, and the lines it skipped are dropped.

A miss that matches nothing takes over the least recently used buffer and restarts it at the line after the miss. Buffers queue new line requests one per cycle into a small FIFO. The FIFO drains on a valid/ready port only while the cache signals that no demand request is waiting. Requests never leave the page that holds the line which started the stream. Returned fills are matched by line address and turn in-flight slots into present slots. Because the buffers run independently, interleaved streams are each tracked in their own buffer.

Top module: `stream_prefetcher`

## Requirements
- R1: While `miss_valid` is high, `lookup_hit` is 1 when the miss line equals a slot whose data is present, and `lookup_pend` is 1 when it equals a slot that is waiting or in flight. When no slot matches, both are 0, and the two are never 1 together.
- R2: A miss that matches slot k (0 = head) of a buffer advances that buffer by k+1 slots and drops the skipped lines, so a later miss to a skipped line matches nothing.
- R3: After an advance, the freed tail slots hold the lines that continue the stream in consecutive order. The block requests them one line per cycle, in rising address order, in cycles with no miss.
- R4: A miss that matches no buffer restarts one buffer with the DEPTH lines that follow the miss line, and requests them in rising order.
- R5: The buffer restarted by R4 is the one least recently touched, where a match or a restart counts as a touch. After reset, buffer NUM_BUF-1 is chosen first and buffer 0 last.
- R6: No requested line lies outside the page of 2^PAGE_LOG2 lines that contains the miss which started the stream. Slots beyond the page stay unused and never match.
- R7: `req_valid` stays low while `demand_busy` is high. Requests leave in the order they were queued, and one that is not accepted holds its line. When the QUEUE_DEPTH-entry FIFO is full, new requests wait.
- R8: A fill whose line equals an in-flight slot marks that slot's data present, and a later miss to that line reports hit.
- R9: Reset clears all buffers and the request queue: `req_valid` is 0, and a miss to any line reports neither hit nor pending.
- R10: Interleaved misses from separate streams are tracked in separate buffers, and each stream keeps its own window and request sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A cache miss is presented this cycle |
| miss_line | input | ADDR_W | Line address of the miss |
| lookup_hit | output | 1 | Miss line is in a buffer with data present |
| lookup_pend | output | 1 | Miss line is in a buffer, data not yet present |
| fill_valid | input | 1 | A requested line has returned |
| fill_line | input | ADDR_W | Line address of the returned data |
| demand_busy | input | 1 | Demand traffic waiting; hold prefetch requests |
| req_valid | output | 1 | Prefetch line request offered |
| req_ready | input | 1 | Memory side accepts the request |
| req_line | output | ADDR_W | Line address being requested |

## Verification
A buffer whose window has drifted, or whose slot states are wrong, shows up on the next miss that lands in it. That miss reports hit, pending or no match wrongly in the same cycle it is presented. A bad advance or a bad tail refill shows up within DEPTH+1 cycles as a missing, extra or out-of-order line on the request port. A wrong LRU choice cannot be seen directly. It appears only when a later miss to the stream that should have survived finds no match. For that reason the stimulus revisits older streams after each eviction.

// File: rtl/sbp_pkg.sv
`timescale 1ns/1ps
package sbp_pkg;
   // State of one slot in a stream buffer window
   typedef enum logic [1:0] {
      SLOT_EMPTY    = 2'd0,  // unused or beyond the page
      SLOT_TODO     = 2'd1,  // line known, request not yet queued
      SLOT_INFLIGHT = 2'd2,  // request queued, data not back
      SLOT_READY    = 2'd3   // data present
   } slot_state_e;
endpackage

// File: rtl/sbp_req_fifo.sv
`timescale 1ns/1ps
module sbp_req_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic         full,
   output logic         empty,
   output logic [W-1:0] head
);
   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] data_q;
         logic         valid_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               valid_q <= 1'b0;
               data_q  <= '0;
            end else begin
               if (pop)  valid_q <= 1'b0;
               if (push) begin
                  valid_q <= 1'b1;
                  data_q  <= push_data;
               end
            end
         end
         assign full  = valid_q;
         assign empty = !valid_q;
         assign head  = data_q;
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         localparam int CNT_W = $clog2(DEPTH + 1);
         logic [W-1:0]     store_q [DEPTH];
         logic [PTR_W-1:0] wr_q, rd_q;
         logic [CNT_W-1:0] cnt_q;

         function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
            return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
         endfunction

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wr_q  <= '0;
               rd_q  <= '0;
               cnt_q <= '0;
               for (int i = 0; i < DEPTH; i++) store_q[i] <= '0;
            end else begin
               if (push) begin
                  store_q[wr_q] <= push_data;
                  wr_q          <= bump(wr_q);
               end
               if (pop) rd_q <= bump(rd_q);
               if (push && !pop)      cnt_q <= cnt_q + 1'b1;
               else if (pop && !push) cnt_q <= cnt_q - 1'b1;
            end
         end
         assign full  = (cnt_q == CNT_W'(DEPTH));
         assign empty = (cnt_q == '0);
         assign head  = store_q[rd_q];
      end
   endgenerate

   // R7: the arbiter never pushes into a full queue
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R7: the port never pops an empty queue
   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/sbp_lru.sv
`timescale 1ns/1ps
module sbp_lru #(
   parameter int NUM_BUF = 4,
   localparam int ID_W   = $clog2(NUM_BUF)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            touch_en,
   input  logic [ID_W-1:0] touch_id,
   output logic [ID_W-1:0] victim_id
);
   // Age rank per buffer: 0 = most recent, NUM_BUF-1 = victim
   logic [ID_W-1:0]    rank_q [NUM_BUF];
   logic [NUM_BUF-1:0] oldest;

   generate
      for (genvar b = 0; b < NUM_BUF; b++) begin : g_old
         assign oldest[b] = (rank_q[b] == ID_W'(NUM_BUF - 1));
      end
   endgenerate

   always_comb begin
      victim_id = '0;
      for (int b = 0; b < NUM_BUF; b++)
         if (oldest[b]) victim_id = ID_W'(b);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NUM_BUF; b++) rank_q[b] <= ID_W'(b);
      end else if (touch_en) begin
         for (int b = 0; b < NUM_BUF; b++) begin
            if (ID_W'(b) == touch_id)           rank_q[b] <= '0;
            else if (rank_q[b] < rank_q[touch_id]) rank_q[b] <= rank_q[b] + 1'b1;
         end
      end
   end

   // R5: the ranks stay a permutation, so exactly one buffer is oldest
   assert_one_victim_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest) == 1);
endmodule

// File: rtl/sbp_stream_buf.sv
`timescale 1ns/1ps
module sbp_stream_buf
   import sbp_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DEPTH     = 4,
   parameter int PAGE_LOG2 = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] look_line,
   output logic              look_match,
   output logic              look_ready,
   input  logic              do_adv,
   input  logic              do_alloc,
   input  logic              fill_valid,
   input  logic [ADDR_W-1:0] fill_line,
   output logic              want_issue,
   output logic [ADDR_W-1:0] issue_line,
   input  logic              issue_grant
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam int PG_W  = ADDR_W - PAGE_LOG2;

   logic [ADDR_W-1:0] tag_q  [DEPTH];
   logic [ADDR_W-1:0] tag_d  [DEPTH];
   slot_state_e       st_q   [DEPTH];
   slot_state_e       st_mid [DEPTH];
   slot_state_e       st_d   [DEPTH];
   logic [PG_W-1:0]   page_q, page_d;
   logic [DEPTH-1:0]  slot_hit, slot_todo;
   logic [IDX_W-1:0]  hit_idx, todo_idx;

   function automatic logic [PG_W-1:0] page_of(input logic [ADDR_W-1:0] l);
      return l[ADDR_W-1:PAGE_LOG2];
   endfunction

   // Associative compare of every slot against the miss line
   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_slot
         assign slot_hit[e]  = (st_q[e] != SLOT_EMPTY) && (tag_q[e] == look_line);
         assign slot_todo[e] = (st_q[e] == SLOT_TODO);
      end
   endgenerate

   always_comb begin
      hit_idx  = '0;
      todo_idx = '0;
      for (int e = DEPTH - 1; e >= 0; e--) begin
         if (slot_hit[e])  hit_idx  = IDX_W'(e);
         if (slot_todo[e]) todo_idx = IDX_W'(e);
      end
   end

   assign look_match = |slot_hit;
   assign look_ready = (st_q[hit_idx] == SLOT_READY);
   assign want_issue = |slot_todo;
   assign issue_line = tag_q[todo_idx];

   // Fill return and request grant applied before any shift
   always_comb begin
      for (int e = 0; e < DEPTH; e++) begin
         st_mid[e] = st_q[e];
         if (fill_valid && st_q[e] == SLOT_INFLIGHT && tag_q[e] == fill_line)
            st_mid[e] = SLOT_READY;
         if (issue_grant && IDX_W'(e) == todo_idx)
            st_mid[e] = SLOT_INFLIGHT;
      end
   end

   always_comb begin
      logic [ADDR_W-1:0] cand;
      int                src;
      cand   = '0;
      src    = 0;
      page_d = page_q;
      for (int e = 0; e < DEPTH; e++) begin
         tag_d[e] = tag_q[e];
         st_d[e]  = st_mid[e];
      end
      if (do_alloc) begin
         page_d = page_of(look_line);
         for (int e = 0; e < DEPTH; e++) begin
            cand     = look_line + ADDR_W'(e + 1);
            tag_d[e] = cand;
            st_d[e]  = (page_of(cand) == page_of(look_line)) ? SLOT_TODO : SLOT_EMPTY;
         end
      end else if (do_adv) begin
         for (int e = 0; e < DEPTH; e++) begin
            src = e + int'(hit_idx) + 1;
            if (src < DEPTH) begin
               tag_d[e] = tag_q[IDX_W'(src)];
               st_d[e]  = st_mid[IDX_W'(src)];
            end else begin
               cand     = tag_q[0] + ADDR_W'(src);
               tag_d[e] = cand;
               st_d[e]  = (page_of(cand) == page_q) ? SLOT_TODO : SLOT_EMPTY;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q <= '0;
         for (int e = 0; e < DEPTH; e++) begin
            tag_q[e] <= '0;
            st_q[e]  <= SLOT_EMPTY;
         end
      end else begin
         page_q <= page_d;
         for (int e = 0; e < DEPTH; e++) begin
            tag_q[e] <= tag_d[e];
            st_q[e]  <= st_d[e];
         end
      end
   end

   // R6: a granted request stays inside the stream's page
   assert_in_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
      issue_grant |-> (page_of(issue_line) == page_q));
   // R4: restart and advance never coincide
   assert_one_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(do_alloc && do_adv));
   // R3: a grant only arrives when a slot is waiting and no shift happens
   assert_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      issue_grant |-> (want_issue && !do_adv && !do_alloc));
endmodule

// File: rtl/stream_prefetcher.sv
`timescale 1ns/1ps
module stream_prefetcher #(
   parameter int ADDR_W      = 16,
   parameter int NUM_BUF     = 4,
   parameter int DEPTH       = 4,
   parameter int PAGE_LOG2   = 6,
   parameter int QUEUE_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [ADDR_W-1:0] miss_line,
   output logic              lookup_hit,
   output logic              lookup_pend,
   input  logic              fill_valid,
   input  logic [ADDR_W-1:0] fill_line,
   input  logic              demand_busy,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_line
);
   localparam int BUF_W = $clog2(NUM_BUF);

   initial begin
      if (NUM_BUF < 2 || DEPTH < 2 || QUEUE_DEPTH < 1 ||
          PAGE_LOG2 < 1 || PAGE_LOG2 >= ADDR_W)
         $fatal(1, "stream_prefetcher: parameter out of range");
   end

   logic [NUM_BUF-1:0] b_match, b_ready, b_want, b_adv, b_alloc, b_grant;
   logic [ADDR_W-1:0]  b_issue [NUM_BUF];
   logic [BUF_W-1:0]   hit_buf, issue_buf, victim_buf, touch_buf;
   logic               hit_any, want_any;
   logic               q_full, q_empty, q_push, q_pop;
   logic [ADDR_W-1:0]  q_head;

   // Lowest-numbered matching buffer wins; same for request arbitration
   always_comb begin
      hit_buf   = '0;
      issue_buf = '0;
      for (int b = NUM_BUF - 1; b >= 0; b--) begin
         if (b_match[b]) hit_buf   = BUF_W'(b);
         if (b_want[b])  issue_buf = BUF_W'(b);
      end
   end

   assign hit_any     = |b_match;
   assign want_any    = |b_want;
   assign lookup_hit  = miss_valid && hit_any && b_ready[hit_buf];
   assign lookup_pend = miss_valid && hit_any && !b_ready[hit_buf];
   assign q_push      = !miss_valid && !q_full && want_any;
   assign touch_buf   = hit_any ? hit_buf : victim_buf;

   generate
      for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
         assign b_adv[b]   = miss_valid && hit_any  && (hit_buf    == BUF_W'(b));
         assign b_alloc[b] = miss_valid && !hit_any && (victim_buf == BUF_W'(b));
         assign b_grant[b] = q_push && (issue_buf == BUF_W'(b));

         sbp_stream_buf #(
            .ADDR_W    (ADDR_W),
            .DEPTH     (DEPTH),
            .PAGE_LOG2 (PAGE_LOG2)
         ) u_buf (
            .clk         (clk),
            .rst_n       (rst_n),
            .look_line   (miss_line),
            .look_match  (b_match[b]),
            .look_ready  (b_ready[b]),
            .do_adv      (b_adv[b]),
            .do_alloc    (b_alloc[b]),
            .fill_valid  (fill_valid),
            .fill_line   (fill_line),
            .want_issue  (b_want[b]),
            .issue_line  (b_issue[b]),
            .issue_grant (b_grant[b])
         );
      end
   endgenerate

   sbp_lru #(.NUM_BUF(NUM_BUF)) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch_en  (miss_valid),
      .touch_id  (touch_buf),
      .victim_id (victim_buf)
   );

   sbp_req_fifo #(.W(ADDR_W), .DEPTH(QUEUE_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push),
      .push_data (b_issue[issue_buf]),
      .pop       (q_pop),
      .full      (q_full),
      .empty     (q_empty),
      .head      (q_head)
   );

   assign req_valid = !q_empty && !demand_busy;
   assign req_line  = q_head;
   assign q_pop     = req_valid && req_ready;

   // R1: hit and pending are exclusive
   assert_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(lookup_hit && lookup_pend));
   // R7: an offered request that is not taken keeps its line
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (demand_busy || (req_valid && $stable(req_line))));
endmodule

// File: tb/stream_prefetcher_bench.sv
`timescale 1ns/1ps
module stream_prefetcher_bench;
   localparam int ADDR_W = 16;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              miss_valid, fill_valid, demand_busy, req_ready;
   logic [ADDR_W-1:0] miss_line, fill_line;
   logic              lookup_hit, lookup_pend, req_valid;
   logic [ADDR_W-1:0] req_line;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   logic [ADDR_W-1:0] log_q [256];
   int n_log = 0;
   int rd_log = 0;

   always #2.5 clk = ~clk;  // 200 MHz

   stream_prefetcher u_stream_prefetcher (
      .clk, .rst_n, .miss_valid, .miss_line, .lookup_hit, .lookup_pend,
      .fill_valid, .fill_line, .demand_busy, .req_valid, .req_ready, .req_line
   );

   // Record every accepted request, sampled between edges
   always begin
      @(negedge clk);
      #2;
      if (req_valid && req_ready && n_log < 256) begin
         log_q[n_log] = req_line;
         n_log++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000) begin
         failures++;
         $display("FAIL watchdog: run did not finish (act=%0d exp<20000)", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: act=%0h exp=%0h", rq, act, exp);
      end
   endtask

   // Present one miss, check the lookup, then leave 8 quiet cycles
   task automatic do_miss(input logic [ADDR_W-1:0] l, input bit eh, input bit ep, input string rq);
      @(negedge clk);
      miss_valid = 1'b1;
      miss_line  = l;
      #1;
      chk(lookup_hit == eh,  {rq, " hit"},  32'(lookup_hit),  32'(eh));
      chk(lookup_pend == ep, {rq, " pend"}, 32'(lookup_pend), 32'(ep));
      @(negedge clk);
      miss_valid = 1'b0;
      repeat (7) @(negedge clk);
   endtask

   task automatic do_fill(input logic [ADDR_W-1:0] l);
      @(negedge clk);
      fill_valid = 1'b1;
      fill_line  = l;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic expect_reqs(input logic [ADDR_W-1:0] first, input int cnt, input string rq);
      for (int i = 0; i < cnt; i++) begin
         logic [ADDR_W-1:0] got;
         got = (rd_log < n_log) ? log_q[rd_log] : 16'hxxxx;
         chk(rd_log < n_log && got == first + ADDR_W'(i), {rq, " request"},
             32'(got), 32'(first + ADDR_W'(i)));
         rd_log++;
      end
   endtask

   // Vector: op, line, arg, requirement number
   // MISS arg = {hit,pend}; REQ arg = run length of consecutive lines
   localparam logic [1:0] OP_MISS = 2'd0, OP_FILL = 2'd1, OP_REQ = 2'd3;
   localparam int NV = 36;
   localparam logic [24:0] VEC [NV] = '{
      {OP_MISS, 16'h0100, 3'd0, 4'd4},   // R4 restart LRU buffer
      {OP_REQ,  16'h0101, 3'd4, 4'd4},   // R4 next DEPTH lines
      {OP_FILL, 16'h0101, 3'd0, 4'd8},   // R8
      {OP_FILL, 16'h0102, 3'd0, 4'd8},   // R8
      {OP_MISS, 16'h0101, 3'd2, 4'd1},   // R1 hit on present data
      {OP_REQ,  16'h0105, 3'd1, 4'd3},   // R3 tail refill
      {OP_MISS, 16'h0103, 3'd1, 4'd2},   // R2 mid-window, in flight
      {OP_REQ,  16'h0106, 3'd2, 4'd3},   // R3 two freed slots
      {OP_MISS, 16'h0102, 3'd0, 4'd2},   // R2 skipped line gone
      {OP_REQ,  16'h0103, 3'd4, 4'd4},   // R4
      {OP_MISS, 16'h0200, 3'd0, 4'd10},  // R10 stream A
      {OP_REQ,  16'h0201, 3'd4, 4'd10},
      {OP_MISS, 16'h0300, 3'd0, 4'd10},  // R10 stream B
      {OP_REQ,  16'h0301, 3'd4, 4'd10},
      {OP_FILL, 16'h0201, 3'd0, 4'd8},
      {OP_FILL, 16'h0301, 3'd0, 4'd8},
      {OP_MISS, 16'h0201, 3'd2, 4'd10},  // R10 A+1
      {OP_REQ,  16'h0205, 3'd1, 4'd3},
      {OP_MISS, 16'h0301, 3'd2, 4'd10},  // R10 B+1
      {OP_REQ,  16'h0305, 3'd1, 4'd3},
      {OP_MISS, 16'h0202, 3'd1, 4'd1},   // R1 pending
      {OP_REQ,  16'h0206, 3'd1, 4'd3},
      {OP_MISS, 16'h0302, 3'd1, 4'd1},
      {OP_REQ,  16'h0306, 3'd1, 4'd3},
      {OP_MISS, 16'h0400, 3'd0, 4'd5},   // R5 evicts 0x100 stream
      {OP_REQ,  16'h0401, 3'd4, 4'd5},
      {OP_MISS, 16'h0107, 3'd0, 4'd5},   // R5 evicted stream misses
      {OP_REQ,  16'h0108, 3'd4, 4'd5},
      {OP_MISS, 16'h0203, 3'd1, 4'd5},   // R5 recent stream survived
      {OP_REQ,  16'h0207, 3'd1, 4'd3},
      {OP_MISS, 16'h053E, 3'd0, 4'd6},   // R6 near page end
      {OP_REQ,  16'h053F, 3'd1, 4'd6},
      {OP_MISS, 16'h0540, 3'd0, 4'd6},   // R6 next page not held
      {OP_REQ,  16'h0541, 3'd4, 4'd6},
      {OP_MISS, 16'h0541, 3'd1, 4'd6},
      {OP_REQ,  16'h0545, 3'd1, 4'd6}
   };

   initial begin
      rst_n = 1'b0; miss_valid = 1'b0; miss_line = '0;
      fill_valid = 1'b0; fill_line = '0; demand_busy = 1'b0; req_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: reset state
      #1;
      chk(req_valid == 1'b0, "R9 req_valid", 32'(req_valid), 0);
      do_miss(16'h0000, 1'b0, 1'b0, "R9");
      chk(n_log == 4, "R9 restart after reset", 32'(n_log), 4);
      expect_reqs(16'h0001, 4, "R9");

      for (int v = 0; v < NV; v++) begin
         logic [1:0]        op;
         logic [ADDR_W-1:0] ln;
         logic [2:0]        arg;
         string             rq;
         op  = VEC[v][24:23];
         ln  = VEC[v][22:7];
         arg = VEC[v][6:4];
         rq  = $sformatf("R%0d vec%0d", VEC[v][3:0], v);
         case (op)
            OP_MISS: do_miss(ln, arg[1], arg[0], rq);
            OP_FILL: do_fill(ln);
            default: expect_reqs(ln, int'(arg), rq);
         endcase
      end
      // R6: nothing beyond the listed lines was requested
      chk(n_log == rd_log, "R6 no extra requests", 32'(n_log), 32'(rd_log));

      // R7: requests held while demand traffic waits, queue stalls when full
      @(negedge clk);
      demand_busy = 1'b1;
      do_miss(16'h0700, 1'b0, 1'b0, "R7");
      #1;
      chk(req_valid == 1'b0, "R7 held while busy", 32'(req_valid), 0);
      repeat (6) @(negedge clk);
      #1;
      chk(req_valid == 1'b0, "R7 still held", 32'(req_valid), 0);
      chk(n_log == rd_log, "R7 nothing sent", 32'(n_log), 32'(rd_log));
      demand_busy = 1'b0;
      repeat (10) @(negedge clk);
      expect_reqs(16'h0701, 4, "R7");
      chk(n_log == rd_log, "R7 queue drained", 32'(n_log), 32'(rd_log));

      // R9: reset mid-run clears every buffer
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(req_valid == 1'b0, "R9 queue cleared", 32'(req_valid), 0);
      do_miss(16'h0702, 1'b0, 1'b0, "R9 buffers cleared");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule